// File: doc/BRIEF.md
# Nine-bit serial command/data link transmitter

This block drives a write-only serial link to a display controller. Every item it accepts is a byte paired with a flag that marks it as a command (flag 0) or as a parameter or pixel byte (flag 1). On the wire the flag travels in-band as a ninth bit, ahead of the eight payload bits. Each item is taken from a valid/ready stream and produces a serial clock, a data line and an active-low chip select. The serial clock idles low, data changes on its falling edge, and the controller samples data on its rising edge.

A mode input selects between two framings. In native mode, every accepted item is sent at once as a 9-bit frame. In packed mode, the block serves hosts whose link can only move whole bytes. It gathers eight 9-bit words in arrival order into a 72-bit group and sends the group as nine bytes under one chip-select assertion. A flush input forces out a partial group. The free word slots are filled with no-op command words (all nine bits zero), so that byte alignment is kept. The serial clock runs at a fixed ratio of the system clock, set by a parameter.

Top module: `spi9_serializer`

## Requirements
- R1: Each word goes out flag bit first and then the payload byte MSB first. The flag is 0 for a command and 1 for a parameter or pixel byte. Each bit is valid on the wire at the rising edge of the serial clock.
- R2: In native mode (pack_mode = 0), each accepted item produces exactly 9 rising edges of the serial clock.
- R3: The serial clock is low whenever chip select is high. It rises only while chip select is low. The data line does not change while the serial clock is high.
- R4: Each half period of the serial clock lasts HALF_DIV system clocks (default 2). A native item accepted at a clock edge pulls chip select low at that same edge. Chip select then stays low for exactly 18*HALF_DIV cycles. A full packed group keeps chip select low for 144*HALF_DIV cycles.
- R5: In packed mode (pack_mode = 1), eight words are joined in arrival order into one 72-bit group. The group is sent MSB first within a single chip-select assertion.
- R6: In packed mode, nothing is sent until eight words are held, unless flush is high. A flushed partial group is still 72 bits long, with every unused slot sent as nine zero bits.
- R7: While pack_mode and flush are both high, in_ready is low and no item is accepted.
- R8: If the next frame is ready when the current one ends, it follows without releasing chip select. Otherwise chip select goes high for at least one cycle before the next frame starts.
- R9: After reset, cs_n is high, sclk and mosi are low, and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pack_mode | input | 1 | 1 selects packed 72-bit groups, 0 selects native 9-bit frames; change only when idle |
| flush | input | 1 | Packed mode: send the partial group, padded with zero words |
| in_valid | input | 1 | Item on in_dc/in_byte is valid |
| in_ready | output | 1 | Block accepts the item at this clock edge |
| in_dc | input | 1 | Flag: 0 command, 1 parameter/pixel |
| in_byte | input | 8 | Payload byte |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Chip select, active low |

## Verification
All outputs are registered. A native item therefore shows up on cs_n and mosi at the same clock edge that accepts it. The first serial clock rise follows HALF_DIV cycles later, and chip select returns high 18*HALF_DIV cycles after acceptance. A packed group instead loads one edge after the eighth word, or after flush is raised. A monitor samples on the falling system clock edge. It records a data bit at each low-to-high step of sclk, counts chip-select falls and counts cycles with chip select low. Each check compares these tallies against values computed from the requirements once the link has been idle for three cycles, so a check never lands on the cycle in which an output changes.

// File: rtl/spi9_pkg.sv
package spi9_pkg;
    localparam int WORD_W      = 9;
    localparam int GROUP_WORDS = 8;
    localparam int GROUP_W     = WORD_W * GROUP_WORDS;
    localparam int CNT_W       = $clog2(GROUP_WORDS + 1);
    localparam int LEFT_W      = $clog2(GROUP_W);

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_RUN  = 1'b1
    } sh_state_e;
endpackage

// File: rtl/spi9_packer.sv
module spi9_packer
    import spi9_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               push,
    input  logic [WORD_W-1:0]  word,
    input  logic               take,
    output logic               space,
    output logic               grp_valid,
    output logic [GROUP_W-1:0] grp_data
);
    typedef struct packed {
        logic [GROUP_W-1:0] acc;
        logic [CNT_W-1:0]   cnt;
    } pk_t;

    pk_t pk_d, pk_q;
    logic full;

    assign full      = (pk_q.cnt == CNT_W'(GROUP_WORDS));
    assign space     = !full && !flush;
    assign grp_valid = full || (flush && (pk_q.cnt != '0));
    assign grp_data  = pk_q.acc;

    always_comb begin
        pk_d = pk_q;
        if (take) begin
            // zeroed slots double as no-op padding for the next group
            pk_d.acc = '0;
            pk_d.cnt = '0;
        end else if (push) begin
            pk_d.acc[GROUP_W - 1 - WORD_W * int'(pk_q.cnt) -: WORD_W] = word;
            pk_d.cnt = pk_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pk_q <= '0;
        end else begin
            pk_q <= pk_d;
        end
    end
endmodule

// File: rtl/spi9_shifter.sv
module spi9_shifter
    import spi9_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               avail,
    input  logic               long_frame,
    input  logic [GROUP_W-1:0] frame,
    output logic               slot,
    output logic               sclk,
    output logic               mosi,
    output logic               cs_n
);
    localparam int PH_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        sh_state_e          state;
        logic [GROUP_W-1:0] sr;
        logic [LEFT_W-1:0]  left;
        logic [PH_W-1:0]    ph;
        logic               sclk;
        logic               cs_n;
    } sh_t;

    sh_t sh_d, sh_q;
    logic ph_end;
    logic last_fall;
    logic load;

    assign ph_end    = (sh_q.ph == PH_W'(HALF_DIV - 1));
    assign last_fall = (sh_q.state == SH_RUN) && ph_end && sh_q.sclk && (sh_q.left == '0);
    assign slot      = (sh_q.state == SH_IDLE) || last_fall;
    assign load      = slot && avail;

    assign sclk = sh_q.sclk;
    assign mosi = sh_q.sr[GROUP_W-1];
    assign cs_n = sh_q.cs_n;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.state = SH_RUN;
            sh_d.sr    = frame;
            sh_d.left  = long_frame ? LEFT_W'(GROUP_W - 1) : LEFT_W'(WORD_W - 1);
            sh_d.ph    = '0;
            sh_d.sclk  = 1'b0;
            sh_d.cs_n  = 1'b0;
        end else if (last_fall) begin
            sh_d.state = SH_IDLE;
            sh_d.sr    = '0;
            sh_d.ph    = '0;
            sh_d.sclk  = 1'b0;
            sh_d.cs_n  = 1'b1;
        end else if (sh_q.state == SH_RUN) begin
            if (ph_end) begin
                sh_d.ph   = '0;
                sh_d.sclk = !sh_q.sclk;
                if (sh_q.sclk) begin
                    // falling edge: present the next bit
                    sh_d.sr   = {sh_q.sr[GROUP_W-2:0], 1'b0};
                    sh_d.left = sh_q.left - LEFT_W'(1);
                end
            end else begin
                sh_d.ph = sh_q.ph + PH_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q       <= '0;
            sh_q.state <= SH_IDLE;
            sh_q.cs_n  <= 1'b1;
        end else begin
            sh_q <= sh_d;
        end
    end
endmodule

// File: rtl/spi9_serializer.sv
module spi9_serializer
    import spi9_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pack_mode,
    input  logic       flush,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       in_dc,
    input  logic [7:0] in_byte,
    output logic       sclk,
    output logic       mosi,
    output logic       cs_n
);
    logic [WORD_W-1:0]  word;
    logic [GROUP_W-1:0] grp_data;
    logic [GROUP_W-1:0] frame;
    logic               pk_space;
    logic               grp_valid;
    logic               pk_push;
    logic               pk_take;
    logic               sh_slot;
    logic               avail;

    assign word     = {in_dc, in_byte};
    assign in_ready = pack_mode ? pk_space : sh_slot;
    assign pk_push  = pack_mode && in_valid && pk_space;
    assign pk_take  = pack_mode && sh_slot && grp_valid;
    assign avail    = pack_mode ? grp_valid : in_valid;
    assign frame    = pack_mode ? grp_data : {word, {(GROUP_W - WORD_W){1'b0}}};

    spi9_packer u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (pk_push),
        .word      (word),
        .take      (pk_take),
        .space     (pk_space),
        .grp_valid (grp_valid),
        .grp_data  (grp_data)
    );

    spi9_shifter #(
        .HALF_DIV (HALF_DIV)
    ) u_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .avail      (avail),
        .long_frame (pack_mode),
        .frame      (frame),
        .slot       (sh_slot),
        .sclk       (sclk),
        .mosi       (mosi),
        .cs_n       (cs_n)
    );
endmodule

// File: rtl/spi9_checker.sv
module spi9_checker (
    input logic clk,
    input logic rst_n,
    input logic pack_mode,
    input logic flush,
    input logic in_valid,
    input logic in_ready,
    input logic sclk,
    input logic mosi,
    input logic cs_n
);
    assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    assert_rise_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> !cs_n);

    assert_flush_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pack_mode && flush) |-> !in_ready);

    assert_native_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pack_mode && in_valid && in_ready) |=> !cs_n);

    assert_release_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> !sclk);
endmodule

bind spi9_serializer spi9_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pack_mode (pack_mode),
    .flush     (flush),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .sclk      (sclk),
    .mosi      (mosi),
    .cs_n      (cs_n)
);

// File: tb/tb_spi9_serializer.sv
`timescale 1ns/1ps
module tb_spi9_serializer;
    localparam int HALF_DIV = 2;
    localparam int CAP_N    = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pack_mode = 1'b0;
    logic flush = 1'b0;
    logic in_valid = 1'b0;
    logic in_dc = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic in_ready, sclk, mosi, cs_n;

    int total = 0;
    int fails = 0;

    logic cap [CAP_N];
    logic expb [CAP_N];
    int ncap = 0, nsess = 0, nlow = 0, nviol = 0, nexp = 0;
    logic prev_sclk = 1'b0, prev_cs = 1'b1, prev_mosi = 1'b0;

    always #4 clk = !clk;

    spi9_serializer #(.HALF_DIV(HALF_DIV)) dut (
        .clk(clk), .rst_n(rst_n), .pack_mode(pack_mode), .flush(flush),
        .in_valid(in_valid), .in_ready(in_ready), .in_dc(in_dc), .in_byte(in_byte),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
    );

    // wire monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (!prev_sclk && sclk && ncap < CAP_N) begin
                cap[ncap] = mosi;
                ncap = ncap + 1;
            end
            if (prev_cs && !cs_n) nsess = nsess + 1;
            if (!cs_n) nlow = nlow + 1;
            if (prev_sclk && sclk && (mosi != prev_mosi)) nviol = nviol + 1;
        end
        prev_sclk = sclk;
        prev_cs   = cs_n;
        prev_mosi = mosi;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    task automatic add_exp(input logic [8:0] w);
        for (int i = 8; i >= 0; i--) begin
            expb[nexp] = w[i];
            nexp++;
        end
    endtask

    // compare captured bits from base against expected list
    task automatic chk_bits(input int base, input string req);
        int bad = -1;
        for (int i = 0; i < nexp; i++) begin
            if (bad < 0 && cap[base + i] !== expb[i]) bad = i;
        end
        chk(bad < 0, req, bad, -1);
    endtask

    task automatic send(input logic dc, input logic [7:0] b);
        in_valid = 1'b1;
        in_dc    = dc;
        in_byte  = b;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_done();
        int hi = 0;
        while (hi < 3) begin
            @(negedge clk);
            #1;
            hi = cs_n ? hi + 1 : 0;
        end
    endtask

    task automatic t_reset();
        chk({cs_n, sclk, mosi, in_ready} == 4'b1001, "R9 reset outputs",
            int'({cs_n, sclk, mosi, in_ready}), 9);
    endtask

    task automatic t_native_single();
        int b0 = ncap, s0 = nsess, l0 = nlow;
        nexp = 0;
        add_exp({1'b0, 8'hA5});
        send(1'b0, 8'hA5);
        wait_done();
        chk(ncap - b0 == 9, "R2 nine clocks per word", ncap - b0, 9);
        chk_bits(b0, "R1 command word bit order");
        chk(nlow - l0 == 18 * HALF_DIV, "R4 native frame length", nlow - l0, 18 * HALF_DIV);
        chk(nsess - s0 == 1, "R2 single select", nsess - s0, 1);
    endtask

    task automatic t_native_burst();
        int b0 = ncap, s0 = nsess;
        nexp = 0;
        add_exp({1'b1, 8'h3C});
        add_exp({1'b1, 8'hFF});
        add_exp({1'b1, 8'h01});
        send(1'b1, 8'h3C);
        send(1'b1, 8'hFF);
        send(1'b1, 8'h01);
        wait_done();
        chk(ncap - b0 == 27, "R2 burst clocks", ncap - b0, 27);
        chk_bits(b0, "R1 data word bit order");
        chk(nsess - s0 == 1, "R8 burst keeps select", nsess - s0, 1);
    endtask

    task automatic t_native_gap();
        int s0 = nsess;
        send(1'b0, 8'h11);
        wait_done();
        send(1'b0, 8'h29);
        wait_done();
        chk(nsess - s0 == 2, "R8 select released when idle", nsess - s0, 2);
    endtask

    task automatic t_packed_full();
        int b0, s0, l0;
        pack_mode = 1'b1;
        @(negedge clk);
        b0 = ncap; s0 = nsess; l0 = nlow;
        nexp = 0;
        for (int i = 0; i < 7; i++) begin
            add_exp({i[0], 8'(8'h40 + i)});
            send(i[0], 8'(8'h40 + i));
        end
        repeat (40) @(negedge clk);
        chk(ncap - b0 == 0 && cs_n, "R6 no send before eight words", ncap - b0, 0);
        add_exp({1'b1, 8'hC3});
        send(1'b1, 8'hC3);
        wait_done();
        chk(ncap - b0 == 72, "R5 group bit count", ncap - b0, 72);
        chk_bits(b0, "R5 group order");
        chk(nsess - s0 == 1, "R5 one select per group", nsess - s0, 1);
        chk(nlow - l0 == 144 * HALF_DIV, "R4 packed frame length", nlow - l0, 144 * HALF_DIV);
    endtask

    task automatic t_packed_flush();
        int b0 = ncap, s0 = nsess;
        nexp = 0;
        add_exp({1'b0, 8'h2A});
        add_exp({1'b1, 8'h00});
        add_exp({1'b1, 8'hAF});
        for (int i = 0; i < 5; i++) add_exp(9'h000);
        send(1'b0, 8'h2A);
        send(1'b1, 8'h00);
        send(1'b1, 8'hAF);
        repeat (40) @(negedge clk);
        chk(ncap - b0 == 0, "R6 partial group held", ncap - b0, 0);
        flush = 1'b1;
        in_valid = 1'b1;
        in_dc = 1'b1;
        in_byte = 8'h77;
        #1;
        chk(!in_ready, "R7 flush blocks input", int'(in_ready), 0);
        @(negedge clk);
        in_valid = 1'b0;
        wait_done();
        flush = 1'b0;
        chk(ncap - b0 == 72, "R6 padded group length", ncap - b0, 72);
        chk_bits(b0, "R6 zero padding");
        chk(nsess - s0 == 1, "R6 single select", nsess - s0, 1);
    endtask

    task automatic t_packed_b2b();
        int b0 = ncap, s0 = nsess;
        nexp = 0;
        for (int i = 0; i < 16; i++) begin
            add_exp({i[1], 8'(8'h90 ^ i)});
            send(i[1], 8'(8'h90 ^ i));
        end
        wait_done();
        chk(ncap - b0 == 144, "R8 two groups bits", ncap - b0, 144);
        chk_bits(b0, "R5 two groups order");
        chk(nsess - s0 == 1, "R8 groups share select", nsess - s0, 1);
        pack_mode = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_native_single();
        t_native_burst();
        t_native_gap();
        t_packed_full();
        t_packed_flush();
        t_packed_b2b();
        chk(nviol == 0, "R3 data stable while clock high", nviol, 0);
        finish_run();
    end
endmodule